// File: doc/BRIEF.md
# Class-of-service QoS control table

This block sits beside one processor core and turns a single class-of-service number into the resource limits that apply to the work now running there. Software loads the class number into a current-class register whenever a task is scheduled onto the core. Through a small register port it also fills three per-class tables: a capacity bitmask for the last-level cache, a capacity bitmask for the second-level cache, and a delay value for the memory-request throttle. The current class indexes all three tables at once. The selected values are driven to the cache replacement logic and to the throttle through output registers. Table entries may be rewritten at any time. A change to the entry of the running class reaches the outputs without any other action.

A mode bit turns on code/data prioritization for the last-level cache. In that mode class n owns two last-level entries. Entry 2n is its data mask and entry 2n+1 is its code mask, and an access-type input picks between them. The second-level table never splits. The number of usable classes is the smallest count that every enabled table can back, so turning the mode on halves the last-level limit. The block rejects any write that would break its rules: a class outside the usable range, a mode change that would strand the current class, a mask that is empty or not one contiguous run of ones, and an entry index past the end of its table. A rejected write leaves all state unchanged and sets an error flag that stays set until reset.

Top module: `qos_cos_ctrl`

## Requirements
- R1: After reset the current class is 0 and the mode is off. Every last-level and second-level mask entry is all ones, every delay entry is 0 and the error flag is clear. The outputs show all-ones masks and delay 0.
- R2: A valid write to the class target (cfg_tgt_i = 0, value in cfg_wdata_i) changes the outputs on the second rising edge after the write is presented. From then on they show that class's entries. At the first edge only the register changes and the outputs keep their old values.
- R3: Rewriting a mask or delay entry of the running class changes the matching output on the second rising edge after the write, with no class rewrite.
- R4: With the mode on, class n's last-level mask is entry 2n when acc_code_i is 0 and entry 2n+1 when acc_code_i is 1. l3_mask_o follows acc_code_i one edge later.
- R5: With the mode off, l3_mask_o is last-level entry n for class n, and acc_code_i has no effect on it.
- R6: l2_mask_o is always second-level entry n for class n, whether the mode is on or off.
- R7: The usable class limit is min(L3_E, L2_E, BW_E) with the mode off and min(L3_E/2, L2_E, BW_E) with it on; the defaults give 6 and 4. A class write at or above the limit is rejected, keeps the previous class and sets the error flag.
- R8: A mask write (cfg_tgt_i = 1 for last-level, 2 for second-level) whose value is zero or whose ones are not one contiguous run is rejected. The entry keeps its value and the error flag is set. A contiguous non-zero mask is stored.
- R9: An entry write whose index is at or above its table's entry count is rejected and sets the error flag. An out-of-range index reads as 0.
- R10: A mode write (cfg_tgt_i = 4, bit 0 is the new mode) is rejected, and sets the error flag, when the current class is at or above the limit that the new mode would impose.
- R11: Once set, the error flag stays set through later valid writes until reset.
- R12: cfg_rdata_o returns the current class for target 0, the mode bit for target 4 and the indexed entry for targets 1, 2 and 3 (delay). Targets 5 to 7 read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_tgt_i | input | 3 | Target: 0 class, 1 last-level mask, 2 second-level mask, 3 delay, 4 mode |
| cfg_idx_i | input | IDX_W (3) | Entry index for table targets |
| cfg_wdata_i | input | DATA_W (20) | Write data |
| cfg_rdata_o | output | DATA_W (20) | Read data for the current target and index |
| acc_code_i | input | 1 | Access type: 1 code fetch, 0 data access |
| l3_mask_o | output | L3_MW (20) | Active last-level capacity mask |
| l2_mask_o | output | L2_MW (8) | Active second-level capacity mask |
| bw_delay_o | output | DLY_W (10) | Active memory-request delay |
| err_o | output | 1 | Sticky rejected-write flag |

## Verification
On every cycle the assertions check several invariants. The current class never leaves the usable range for the present mode. The class and mode registers change only on a write to their own target. A rejected class write keeps the old class and raises the flag, the flag never falls, and both mask outputs are always one contiguous non-zero run. Only the bench scenarios show the table contents themselves. They cover the latency of a class switch and of an entry rewrite, the data/code entry pairing under prioritization, and that the access type has no effect with the mode off. They also cover the exact limit boundaries and that each rejected write leaves the stored values intact at readback.

// File: rtl/qos_pkg.sv
package qos_pkg;
  typedef enum logic [2:0] {
    TGT_CLASS = 3'd0,
    TGT_L3    = 3'd1,
    TGT_L2    = 3'd2,
    TGT_BW    = 3'd3,
    TGT_MODE  = 3'd4
  } qos_tgt_e;

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/qos_mask_ok.sv
module qos_mask_ok #(
  parameter int W = 20
) (
  input  logic [W-1:0] mask_i,
  output logic         ok_o
);
  logic [W-1:0] low_bit;
  logic [W-1:0] carry;

  always_comb begin
    low_bit = mask_i & (~mask_i + W'(1));
    // adding the lowest set bit clears a contiguous run entirely
    carry   = mask_i + low_bit;
    ok_o    = (|mask_i) && ((carry & mask_i) == '0);
  end
endmodule

// File: rtl/qos_entry_table.sv
module qos_entry_table #(
  parameter int           ENTRIES = 8,
  parameter int           W       = 20,
  parameter int           IDX_W   = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [W-1:0]     rdata_o,
  input  logic [IDX_W-1:0] lidx_i,
  output logic [W-1:0]     ldata_o
);
  localparam logic [IDX_W:0] LAST = (IDX_W+1)'(ENTRIES);

  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= RST_VAL;
    end else if (we_i && ({1'b0, widx_i} < LAST)) begin
      mem[widx_i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    ldata_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ridx_i == IDX_W'(i)) rdata_o = mem[i];
      if (lidx_i == IDX_W'(i)) ldata_o = mem[i];
    end
  end
endmodule

// File: rtl/qos_cfg_ctrl.sv
module qos_cfg_ctrl
  import qos_pkg::*;
#(
  parameter int L3_E   = 8,
  parameter int L2_E   = 8,
  parameter int BW_E   = 6,
  parameter int L3_MW  = 20,
  parameter int L2_MW  = 8,
  parameter int IDX_W  = 3,
  parameter int CLS_W  = 3,
  parameter int DATA_W = 20,
  parameter int LIM_N  = 6,
  parameter int LIM_C  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_tgt_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [CLS_W-1:0]  cls_o,
  output logic              cdp_o,
  output logic              err_o,
  output logic              l3_we_o,
  output logic              l2_we_o,
  output logic              bw_we_o
);
  localparam logic [DATA_W-1:0] LIM_N_D = DATA_W'(LIM_N);
  localparam logic [DATA_W-1:0] LIM_C_D = DATA_W'(LIM_C);
  localparam logic [IDX_W:0]    L3_E_I  = (IDX_W+1)'(L3_E);
  localparam logic [IDX_W:0]    L2_E_I  = (IDX_W+1)'(L2_E);
  localparam logic [IDX_W:0]    BW_E_I  = (IDX_W+1)'(BW_E);

  logic [CLS_W-1:0] cls_q;
  logic             cdp_q, err_q;
  logic             l3_shape_ok, l2_shape_ok;
  logic             hit_cls, hit_mode, hit_l3, hit_l2, hit_bw;
  logic             cls_ok, mode_ok, l3_ok, l2_ok, bw_ok;
  logic [DATA_W-1:0] cls_ext, cur_lim, new_lim;
  logic             reject;

  qos_mask_ok #(.W(L3_MW)) u_l3_chk (.mask_i(cfg_wdata_i[L3_MW-1:0]), .ok_o(l3_shape_ok));
  qos_mask_ok #(.W(L2_MW)) u_l2_chk (.mask_i(cfg_wdata_i[L2_MW-1:0]), .ok_o(l2_shape_ok));

  always_comb begin
    hit_cls  = cfg_we_i && (cfg_tgt_i == TGT_CLASS);
    hit_mode = cfg_we_i && (cfg_tgt_i == TGT_MODE);
    hit_l3   = cfg_we_i && (cfg_tgt_i == TGT_L3);
    hit_l2   = cfg_we_i && (cfg_tgt_i == TGT_L2);
    hit_bw   = cfg_we_i && (cfg_tgt_i == TGT_BW);
    cls_ext  = DATA_W'(cls_q);
    cur_lim  = cdp_q ? LIM_C_D : LIM_N_D;
    new_lim  = cfg_wdata_i[0] ? LIM_C_D : LIM_N_D;
    cls_ok   = cfg_wdata_i < cur_lim;
    mode_ok  = cls_ext < new_lim;
    l3_ok    = ({1'b0, cfg_idx_i} < L3_E_I) && l3_shape_ok;
    l2_ok    = ({1'b0, cfg_idx_i} < L2_E_I) && l2_shape_ok;
    bw_ok    = ({1'b0, cfg_idx_i} < BW_E_I);
    reject   = (hit_cls && !cls_ok) || (hit_mode && !mode_ok) ||
               (hit_l3 && !l3_ok) || (hit_l2 && !l2_ok) || (hit_bw && !bw_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q <= '0;
      cdp_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (hit_cls && cls_ok)   cls_q <= CLS_W'(cfg_wdata_i);
      if (hit_mode && mode_ok) cdp_q <= cfg_wdata_i[0];
      if (reject)              err_q <= 1'b1;
    end
  end

  assign cls_o   = cls_q;
  assign cdp_o   = cdp_q;
  assign err_o   = err_q;
  assign l3_we_o = hit_l3 && l3_ok;
  assign l2_we_o = hit_l2 && l2_ok;
  assign bw_we_o = hit_bw && bw_ok;
endmodule

// File: rtl/qos_lookup.sv
module qos_lookup #(
  parameter int L3_MW = 20,
  parameter int L2_MW = 8,
  parameter int DLY_W = 10,
  parameter int IDX_W = 3,
  parameter int CLS_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CLS_W-1:0] cls_i,
  input  logic             cdp_i,
  input  logic             acc_code_i,
  output logic [IDX_W-1:0] l3_idx_o,
  output logic [IDX_W-1:0] cls_idx_o,
  input  logic [L3_MW-1:0] l3_val_i,
  input  logic [L2_MW-1:0] l2_val_i,
  input  logic [DLY_W-1:0] bw_val_i,
  output logic [L3_MW-1:0] l3_mask_o,
  output logic [L2_MW-1:0] l2_mask_o,
  output logic [DLY_W-1:0] bw_delay_o
);
  logic [CLS_W:0] pair_idx;

  always_comb begin
    // prioritization: data at 2n, code at 2n+1
    pair_idx  = {cls_i, acc_code_i};
    l3_idx_o  = cdp_i ? IDX_W'(pair_idx) : IDX_W'(cls_i);
    cls_idx_o = IDX_W'(cls_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l3_mask_o  <= '1;
      l2_mask_o  <= '1;
      bw_delay_o <= '0;
    end else begin
      l3_mask_o  <= l3_val_i;
      l2_mask_o  <= l2_val_i;
      bw_delay_o <= bw_val_i;
    end
  end
endmodule

// File: rtl/qos_cos_ctrl.sv
module qos_cos_ctrl
  import qos_pkg::*;
#(
  parameter int L3_E  = 8,
  parameter int L2_E  = 8,
  parameter int BW_E  = 6,
  parameter int L3_MW = 20,
  parameter int L2_MW = 8,
  parameter int DLY_W = 10,
  localparam int LIM_N  = imin(imin(L3_E, L2_E), BW_E),
  localparam int LIM_C  = imin(imin(L3_E / 2, L2_E), BW_E),
  localparam int CLS_W  = imax(1, $clog2(LIM_N)),
  localparam int IDX_W  = imax(1, $clog2(imax(imax(L3_E, L2_E), BW_E))),
  localparam int DATA_W = imax(imax(L3_MW, L2_MW), imax(DLY_W, CLS_W))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_tgt_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              acc_code_i,
  output logic [L3_MW-1:0]  l3_mask_o,
  output logic [L2_MW-1:0]  l2_mask_o,
  output logic [DLY_W-1:0]  bw_delay_o,
  output logic              err_o
);
  logic [CLS_W-1:0] cls_q;
  logic             cdp_q;
  logic             l3_we, l2_we, bw_we;
  logic [IDX_W-1:0] l3_idx, cls_idx;
  logic [L3_MW-1:0] l3_rd, l3_lk;
  logic [L2_MW-1:0] l2_rd, l2_lk;
  logic [DLY_W-1:0] bw_rd, bw_lk;

  qos_cfg_ctrl #(
    .L3_E(L3_E), .L2_E(L2_E), .BW_E(BW_E), .L3_MW(L3_MW), .L2_MW(L2_MW),
    .IDX_W(IDX_W), .CLS_W(CLS_W), .DATA_W(DATA_W), .LIM_N(LIM_N), .LIM_C(LIM_C)
  ) u_ctrl (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_tgt_i, .cfg_idx_i, .cfg_wdata_i,
    .cls_o(cls_q), .cdp_o(cdp_q), .err_o,
    .l3_we_o(l3_we), .l2_we_o(l2_we), .bw_we_o(bw_we)
  );

  qos_entry_table #(.ENTRIES(L3_E), .W(L3_MW), .IDX_W(IDX_W), .RST_VAL('1)) u_l3_tab (
    .clk_i, .rst_ni, .we_i(l3_we), .widx_i(cfg_idx_i), .wdata_i(cfg_wdata_i[L3_MW-1:0]),
    .ridx_i(cfg_idx_i), .rdata_o(l3_rd), .lidx_i(l3_idx), .ldata_o(l3_lk)
  );

  qos_entry_table #(.ENTRIES(L2_E), .W(L2_MW), .IDX_W(IDX_W), .RST_VAL('1)) u_l2_tab (
    .clk_i, .rst_ni, .we_i(l2_we), .widx_i(cfg_idx_i), .wdata_i(cfg_wdata_i[L2_MW-1:0]),
    .ridx_i(cfg_idx_i), .rdata_o(l2_rd), .lidx_i(cls_idx), .ldata_o(l2_lk)
  );

  qos_entry_table #(.ENTRIES(BW_E), .W(DLY_W), .IDX_W(IDX_W), .RST_VAL('0)) u_bw_tab (
    .clk_i, .rst_ni, .we_i(bw_we), .widx_i(cfg_idx_i), .wdata_i(cfg_wdata_i[DLY_W-1:0]),
    .ridx_i(cfg_idx_i), .rdata_o(bw_rd), .lidx_i(cls_idx), .ldata_o(bw_lk)
  );

  qos_lookup #(
    .L3_MW(L3_MW), .L2_MW(L2_MW), .DLY_W(DLY_W), .IDX_W(IDX_W), .CLS_W(CLS_W)
  ) u_lookup (
    .clk_i, .rst_ni, .cls_i(cls_q), .cdp_i(cdp_q), .acc_code_i,
    .l3_idx_o(l3_idx), .cls_idx_o(cls_idx),
    .l3_val_i(l3_lk), .l2_val_i(l2_lk), .bw_val_i(bw_lk),
    .l3_mask_o, .l2_mask_o, .bw_delay_o
  );

  always_comb begin
    case (cfg_tgt_i)
      TGT_CLASS: cfg_rdata_o = DATA_W'(cls_q);
      TGT_L3:    cfg_rdata_o = DATA_W'(l3_rd);
      TGT_L2:    cfg_rdata_o = DATA_W'(l2_rd);
      TGT_BW:    cfg_rdata_o = DATA_W'(bw_rd);
      TGT_MODE:  cfg_rdata_o = DATA_W'(cdp_q);
      default:   cfg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/qos_cos_ctrl_chk.sv
module qos_cos_ctrl_chk #(
  parameter int L3_MW  = 20,
  parameter int L2_MW  = 8,
  parameter int CLS_W  = 3,
  parameter int DATA_W = 20,
  parameter int LIM_N  = 6,
  parameter int LIM_C  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [2:0]        cfg_tgt_i,
  input logic [DATA_W-1:0] cfg_wdata_i,
  input logic [CLS_W-1:0]  cls_q,
  input logic              cdp_q,
  input logic              err_o,
  input logic [L3_MW-1:0]  l3_mask_o,
  input logic [L2_MW-1:0]  l2_mask_o
);
  function automatic int run_ends(input logic [31:0] m, input int w);
    int n = 0;
    for (int i = 0; i < w; i++) begin
      if (m[i] && (i == w - 1 || !m[i+1])) n++;
    end
    return n;
  endfunction

  logic [DATA_W-1:0] lim_now;
  assign lim_now = cdp_q ? DATA_W'(LIM_C) : DATA_W'(LIM_N);

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R11

  AST_CLS_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    DATA_W'(cls_q) < lim_now); // R7

  AST_BAD_CLS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_tgt_i == 3'd0 && cfg_wdata_i >= lim_now) |=> ($stable(cls_q) && err_o)); // R7

  AST_CLS_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_tgt_i == 3'd0) |=> $stable(cls_q)); // R2

  AST_MODE_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_tgt_i == 3'd4) |=> $stable(cdp_q)); // R10

  AST_L3_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_ends(32'(l3_mask_o), L3_MW) == 1); // R8

  AST_L2_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_ends(32'(l2_mask_o), L2_MW) == 1); // R8
endmodule

bind qos_cos_ctrl qos_cos_ctrl_chk #(
  .L3_MW(L3_MW), .L2_MW(L2_MW), .CLS_W(CLS_W), .DATA_W(DATA_W),
  .LIM_N(LIM_N), .LIM_C(LIM_C)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_tgt_i(cfg_tgt_i),
  .cfg_wdata_i(cfg_wdata_i), .cls_q(cls_q), .cdp_q(cdp_q), .err_o(err_o),
  .l3_mask_o(l3_mask_o), .l2_mask_o(l2_mask_o)
);

// File: tb/sim_qos_cos_ctrl.sv
`timescale 1ns/1ps
module sim_qos_cos_ctrl;
  localparam logic [2:0] T_CLS = 3'd0, T_L3 = 3'd1, T_L2 = 3'd2, T_BW = 3'd3, T_MODE = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_tgt = 3'd0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [19:0] cfg_wdata = '0;
  logic [19:0] cfg_rdata;
  logic        acc_code = 1'b0;
  logic [19:0] l3_mask;
  logic [7:0]  l2_mask;
  logic [9:0]  bw_delay;
  logic        err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qos_cos_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_tgt_i(cfg_tgt),
    .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .acc_code_i(acc_code), .l3_mask_o(l3_mask), .l2_mask_o(l2_mask),
    .bw_delay_o(bw_delay), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0; acc_code = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] t, input int idx, input logic [19:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tgt = t; cfg_idx = 3'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] t, input int idx, output logic [19:0] v);
    @(negedge clk);
    cfg_tgt = t; cfg_idx = 3'(idx);
    #1 v = cfg_rdata;
  endtask

  task automatic t_reset();
    logic [19:0] v;
    do_reset();
    chk("R1 l3 out", 32'(l3_mask), 32'hFFFFF);
    chk("R1 l2 out", 32'(l2_mask), 32'hFF);
    chk("R1 delay out", 32'(bw_delay), 0);
    chk("R1 err", 32'(err), 0);
    rd(T_CLS, 0, v);  chk("R1 R12 class", 32'(v), 0);
    rd(T_MODE, 0, v); chk("R1 R12 mode", 32'(v), 0);
    for (int i = 0; i < 8; i++) begin
      rd(T_L3, i, v); chk("R1 l3 entry", 32'(v), 32'hFFFFF);
      rd(T_L2, i, v); chk("R1 l2 entry", 32'(v), 32'hFF);
    end
    for (int i = 0; i < 6; i++) begin
      rd(T_BW, i, v); chk("R1 bw entry", 32'(v), 0);
    end
  endtask

  task automatic t_class_switch();
    do_reset();
    wr(T_L3, 3, 20'h00FF0);
    wr(T_L2, 3, 20'h0F);
    wr(T_BW, 3, 20'd10);
    tick();
    chk("R2 before switch", 32'(l3_mask), 32'hFFFFF);
    wr(T_CLS, 0, 20'd3);
    chk("R2 one edge only", 32'(l3_mask), 32'hFFFFF);
    tick();
    chk("R2 l3", 32'(l3_mask), 32'h00FF0);
    chk("R2 R6 l2", 32'(l2_mask), 32'h0F);
    chk("R2 delay", 32'(bw_delay), 10);
    wr(T_CLS, 0, 20'd1);
    tick();
    chk("R2 back to default l3", 32'(l3_mask), 32'hFFFFF);
    chk("R2 back to default delay", 32'(bw_delay), 0);
    chk("R2 err", 32'(err), 0);
  endtask

  task automatic t_rewrite();
    do_reset();
    wr(T_CLS, 0, 20'd3);
    wr(T_L3, 3, 20'h0F000);
    chk("R3 not yet", 32'(l3_mask), 32'hFFFFF);
    tick();
    chk("R3 l3 live", 32'(l3_mask), 32'h0F000);
    wr(T_BW, 3, 20'd77);
    tick();
    chk("R3 delay live", 32'(bw_delay), 77);
    wr(T_BW, 2, 20'd5);
    tick();
    chk("R3 other class untouched", 32'(bw_delay), 77);
  endtask

  task automatic t_nocdp_code();
    do_reset();
    wr(T_L3, 2, 20'h0000F);
    wr(T_L3, 3, 20'hF0000);
    wr(T_CLS, 0, 20'd2);
    acc_code = 1'b1;
    tick(); tick();
    chk("R5 code ignored", 32'(l3_mask), 32'h0000F);
    acc_code = 1'b0;
    tick(); tick();
    chk("R5 data", 32'(l3_mask), 32'h0000F);
  endtask

  task automatic t_cdp();
    logic [19:0] v;
    do_reset();
    wr(T_MODE, 0, 20'd1);
    rd(T_MODE, 0, v); chk("R12 mode on", 32'(v), 1);
    wr(T_L3, 2, 20'h0000F);
    wr(T_L3, 3, 20'hFFF00);
    wr(T_L2, 1, 20'h3C);
    wr(T_CLS, 0, 20'd1);
    acc_code = 1'b0;
    tick();
    chk("R4 data mask", 32'(l3_mask), 32'h0000F);
    chk("R6 l2 no split", 32'(l2_mask), 32'h3C);
    acc_code = 1'b1;
    tick();
    chk("R4 code mask", 32'(l3_mask), 32'hFFF00);
    chk("R6 l2 code access", 32'(l2_mask), 32'h3C);
    wr(T_CLS, 0, 20'd4);
    rd(T_CLS, 0, v); chk("R7 cdp limit kept", 32'(v), 1);
    chk("R7 cdp limit err", 32'(err), 1);
    acc_code = 1'b0;
  endtask

  task automatic t_bad_class();
    logic [19:0] v;
    do_reset();
    wr(T_CLS, 0, 20'd5);
    chk("R7 top class ok", 32'(err), 0);
    wr(T_CLS, 0, 20'd6);
    rd(T_CLS, 0, v); chk("R7 over limit kept", 32'(v), 5);
    chk("R7 over limit err", 32'(err), 1);
  endtask

  task automatic t_bad_mask();
    logic [19:0] v;
    do_reset();
    wr(T_L3, 0, 20'h00005);
    rd(T_L3, 0, v); chk("R8 split mask kept", 32'(v), 32'hFFFFF);
    chk("R8 split mask err", 32'(err), 1);
    do_reset();
    wr(T_L3, 0, 20'h0);
    rd(T_L3, 0, v); chk("R8 zero mask kept", 32'(v), 32'hFFFFF);
    chk("R8 zero mask err", 32'(err), 1);
    do_reset();
    wr(T_L3, 0, 20'hF8000);
    rd(T_L3, 0, v); chk("R8 top run stored", 32'(v), 32'hF8000);
    tick();
    chk("R8 top run out", 32'(l3_mask), 32'hF8000);
    chk("R8 good mask no err", 32'(err), 0);
    wr(T_L2, 4, 20'h81);
    rd(T_L2, 4, v); chk("R8 l2 wrap kept", 32'(v), 32'hFF);
    chk("R8 l2 err", 32'(err), 1);
  endtask

  task automatic t_bad_idx();
    logic [19:0] v;
    do_reset();
    wr(T_BW, 5, 20'd9);
    rd(T_BW, 5, v); chk("R9 last idx stored", 32'(v), 9);
    chk("R9 last idx no err", 32'(err), 0);
    wr(T_BW, 6, 20'd9);
    rd(T_BW, 6, v); chk("R9 out of range reads 0", 32'(v), 0);
    chk("R9 out of range err", 32'(err), 1);
  endtask

  task automatic t_mode_reject();
    logic [19:0] v;
    do_reset();
    wr(T_CLS, 0, 20'd4);
    wr(T_MODE, 0, 20'd1);
    rd(T_MODE, 0, v); chk("R10 mode kept off", 32'(v), 0);
    chk("R10 err", 32'(err), 1);
    do_reset();
    wr(T_CLS, 0, 20'd3);
    wr(T_MODE, 0, 20'd1);
    rd(T_MODE, 0, v); chk("R10 mode on at class 3", 32'(v), 1);
    chk("R10 no err", 32'(err), 0);
  endtask

  task automatic t_sticky_and_spare();
    logic [19:0] v;
    do_reset();
    wr(3'd5, 0, 20'd3);
    rd(3'd5, 0, v); chk("R12 spare target reads 0", 32'(v), 0);
    rd(T_CLS, 0, v); chk("R12 spare write no effect", 32'(v), 0);
    chk("R12 spare write no err", 32'(err), 0);
    wr(T_CLS, 0, 20'd7);
    wr(T_CLS, 0, 20'd2);
    wr(T_L3, 1, 20'h00030);
    tick(); tick();
    chk("R11 err sticky", 32'(err), 1);
    do_reset();
    chk("R11 reset clears", 32'(err), 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_class_switch();
    t_rewrite();
    t_nocdp_code();
    t_cdp();
    t_bad_class();
    t_bad_mask();
    t_bad_idx();
    t_mode_reject();
    t_sticky_and_spare();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule